// File: doc/BRIEF.md
# Processor and Peripheral Clock Gate Controller

This block derives gate enables for one processor clock and a set of peripheral clocks, all taken from a single master clock. Software reaches it over a simple single-cycle register bus. Peripheral clocks are switched on through a set register and off through a separate clear register, both write-one-active. A readable status word shows which peripheral clocks are currently running, and bit i always belongs to peripheral identifier i (the same index as its interrupt source).

The processor clock runs after reset. Software can put the processor into idle by writing a stop request. The controller then waits for an instruction-complete handshake before it gates the clock, so the instruction in progress always finishes. Any already-masked normal or fast interrupt brings the processor clock back, and so does reset. The register file and the bus side stay on the ungated master clock, so other bus masters can keep programming the block while the processor sleeps. All gate enables are re-timed on the falling edge of the master clock, which lets a downstream AND-style gate produce no runt pulses.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset, cpu_clk_en is 1, every bit of per_clk_en is 0 and the peripheral status word (address 4) reads 0.
- R2: A write to address 2 enables each peripheral clock whose data bit is 1. Bits written as 0 leave their clocks unchanged. The gate output follows at the next falling clock edge.
- R3: A write to address 3 disables each peripheral clock whose data bit is 1 at the next falling edge, whatever state the processor is in. Bits written as 0 leave their clocks unchanged.
- R4: A read of address 4 returns the peripheral status, with bit i for peripheral identifier i. A read of address 1 returns the processor clock state in bit 0 (1 = running). Other addresses read 0.
- R5: Writing address 0 with data bit 0 = 1 requests idle. cpu_clk_en stays 1 until insn_done is sampled high, and falls at the falling edge that follows that sample. A write with bit 0 = 0 has no effect.
- R6: While idle, a high wake_irq or wake_fiq at a rising edge turns cpu_clk_en back on at the next falling edge.
- R7: A wake interrupt present when the stop request is written, or while the controller waits for insn_done, cancels the stop, and the processor clock never turns off.
- R8: Peripheral set, clear and status reads work unchanged while the processor clock is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address (word index) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| insn_done | input | 1 | Processor has retired its current instruction |
| wake_irq | input | 1 | Masked normal interrupt request |
| wake_fiq | input | 1 | Masked fast interrupt request |
| cpu_clk_en | output | 1 | Processor clock gate enable (falling-edge timed) |
| per_clk_en | output | N_PERIPH | Peripheral clock gate enables (falling-edge timed) |

## Verification
The peripheral gating is driven with single-bit, sparse and all-ones masks. It also gets overlapping set and clear masks that contain zero bits, which shows whether zeros are truly ignored and whether each bit keeps its own identity. The idle path is tried with insn_done held low over several cycles, and then with wakes from both the normal and the fast interrupt. These runs separate a stop that waits for the handshake from one that does not, and a wake on each line from a wake on only one. A stop written together with an interrupt, and an interrupt that arrives while the controller waits for insn_done, each check that a pending wake overrides the stop. Peripheral writes made during idle confirm that the bus side keeps running.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CPU_STOP = 3'd0,
      REG_CPU_STAT = 3'd1,
      REG_PER_SET  = 3'd2,
      REG_PER_CLR  = 3'd3,
      REG_PER_STAT = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      CPU_RUN   = 2'd0,
      CPU_DRAIN = 2'd1,
      CPU_IDLE  = 2'd2
   } cpu_st_e;
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
   import clkgate_pkg::*;
#(
   parameter int unsigned N_PERIPH = 32,
   parameter int unsigned DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              cpu_running,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              stop_req,
   output logic [N_PERIPH-1:0] per_stat
);
   logic [N_PERIPH-1:0] set_mask, clr_mask;

   assign set_mask = (bus_wr && bus_addr == REG_PER_SET) ? bus_wdata[N_PERIPH-1:0] : '0;
   assign clr_mask = (bus_wr && bus_addr == REG_PER_CLR) ? bus_wdata[N_PERIPH-1:0] : '0;
   assign stop_req = bus_wr && (bus_addr == REG_CPU_STOP) && bus_wdata[0];

   // clear takes priority over set on any shared bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_stat <= '0;
      else        per_stat <= (per_stat | set_mask) & ~clr_mask;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_PER_STAT: bus_rdata[N_PERIPH-1:0] = per_stat;
         REG_CPU_STAT: bus_rdata[0]            = cpu_running;
         default:      bus_rdata               = '0;
      endcase
   end

   a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_PER_SET)
      |=> ((per_stat & $past(bus_wdata[N_PERIPH-1:0])) == $past(bus_wdata[N_PERIPH-1:0])));

   a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_PER_CLR)
      |=> ((per_stat & $past(bus_wdata[N_PERIPH-1:0])) == '0));

   a_r3_no_bus_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(per_stat));
endmodule

// File: rtl/clkgate_cpu_fsm.sv
module clkgate_cpu_fsm
   import clkgate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic insn_done,
   input  logic wake_irq,
   input  logic wake_fiq,
   output logic running
);
   cpu_st_e st, st_nx;
   logic    wake;

   assign wake = wake_irq | wake_fiq;

   always_comb begin
      st_nx = st;
      unique case (st)
         CPU_RUN:   if (stop_req && !wake) st_nx = CPU_DRAIN;
         CPU_DRAIN: if (wake)              st_nx = CPU_RUN;
                    else if (insn_done)    st_nx = CPU_IDLE;
         CPU_IDLE:  if (wake)              st_nx = CPU_RUN;
         default:                          st_nx = CPU_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= CPU_RUN;
      else        st <= st_nx;
   end

   assign running = (st != CPU_IDLE);

   a_r5_stop_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(insn_done));

   a_r6_wake_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && (wake_irq || wake_fiq)) |=> running);

   a_r7_wake_cancels_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (running && (wake_irq || wake_fiq)) |=> running);
endmodule

// File: rtl/clkgate_gate.sv
module clkgate_gate #(
   parameter int unsigned N_PERIPH     = 32,
   parameter bit          GATE_ON_FALL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_run,
   input  logic [N_PERIPH-1:0] per_stat,
   output logic                cpu_clk_en,
   output logic [N_PERIPH-1:0] per_clk_en
);
   if (GATE_ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) cpu_clk_en <= 1'b1;
         else        cpu_clk_en <= cpu_run;
      end
      for (genvar i = 0; i < N_PERIPH; i++) begin : g_bit
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) per_clk_en[i] <= 1'b0;
            else        per_clk_en[i] <= per_stat[i];
         end
      end
   end else begin : g_pass
      assign cpu_clk_en = cpu_run;
      assign per_clk_en = per_stat;
   end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
   import clkgate_pkg::*;
#(
   parameter int unsigned N_PERIPH     = 32,
   parameter int unsigned DATA_W       = 32,
   parameter bit          GATE_ON_FALL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [2:0]          bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                insn_done,
   input  logic                wake_irq,
   input  logic                wake_fiq,
   output logic                cpu_clk_en,
   output logic [N_PERIPH-1:0] per_clk_en
);
   if (N_PERIPH < 1 || N_PERIPH > DATA_W) begin : g_bad_cfg
      $error("clk_gate_ctrl: N_PERIPH must be 1..DATA_W");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("clk_gate_ctrl: address width mismatch");
   end

   logic                stop_req;
   logic                running;
   logic [N_PERIPH-1:0] per_stat;

   clkgate_regs #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cpu_running(running), .bus_rdata(bus_rdata),
      .stop_req(stop_req), .per_stat(per_stat)
   );

   clkgate_cpu_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .insn_done(insn_done),
      .wake_irq(wake_irq), .wake_fiq(wake_fiq), .running(running)
   );

   clkgate_gate #(.N_PERIPH(N_PERIPH), .GATE_ON_FALL(GATE_ON_FALL)) u_gate (
      .clk(clk), .rst_n(rst_n), .cpu_run(running), .per_stat(per_stat),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
   );
endmodule

// File: tb/sim_clk_gate_ctrl.sv
module sim_clk_gate_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic insn_done = 1'b0, wake_irq = 1'b0, wake_fiq = 1'b0;
   logic cpu_clk_en;
   logic [NP-1:0] per_clk_en;

   int checks = 0, errors = 0;
   logic [NP-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_gate_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .insn_done(insn_done),
      .wake_irq(wake_irq), .wake_fiq(wake_fiq), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, the write lands at the rising edge,
   // gates update at the following falling edge, then sample 1 later
   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      #1;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      #1;
      chk("R1 cpu_en", {31'b0, cpu_clk_en}, 32'd1);
      chk("R1 per_en", per_clk_en, '0);
      bus_read(3'd4, r);
      chk("R1 status", r, '0);
   endtask

   task automatic t_set;
      logic [31:0] r;
      bus_write(3'd2, 32'h0000_0001); model |= 32'h1;
      chk("R2 single bit", per_clk_en, model);
      bus_write(3'd2, 32'h8000_0410); model |= 32'h8000_0410;
      chk("R2 sparse zeros ignored", per_clk_en, model);
      bus_read(3'd4, r);
      chk("R4 status index", r, model);
   endtask

   task automatic t_clear;
      logic [31:0] r;
      bus_write(3'd3, 32'h0000_0010); model &= ~32'h10;
      chk("R3 clear one", per_clk_en, model);
      bus_write(3'd2, 32'hFFFF_FFFF); model = '1;
      chk("R2 all ones", per_clk_en, model);
      bus_write(3'd3, 32'h0F0F_0000); model &= ~32'h0F0F_0000;
      chk("R3 clear mask zeros ignored", per_clk_en, model);
      bus_read(3'd4, r);
      chk("R4 status after clear", r, model);
      bus_read(3'd1, r);
      chk("R4 cpu stat running", r, 32'd1);
      bus_read(3'd6, r);
      chk("R4 unmapped", r, '0);
   endtask

   task automatic t_idle_and_irq;
      logic [31:0] r;
      bus_write(3'd0, 32'h0000_0000);
      repeat (2) @(negedge clk);
      insn_done = 1'b1; @(negedge clk); insn_done = 1'b0; #1;
      chk("R5 bit0 zero no stop", {31'b0, cpu_clk_en}, 32'd1);
      bus_write(3'd0, 32'h0000_0001);
      repeat (3) @(negedge clk);
      #1;
      chk("R5 waits for insn_done", {31'b0, cpu_clk_en}, 32'd1);
      @(negedge clk); insn_done = 1'b1;
      @(negedge clk); insn_done = 1'b0; #1;
      chk("R5 stops after done", {31'b0, cpu_clk_en}, 32'd0);
      // R8: bus side alive while idle
      bus_write(3'd2, 32'h0000_0020); model |= 32'h20;
      chk("R8 set during idle", per_clk_en, model);
      bus_write(3'd3, 32'h8000_0000); model &= ~32'h8000_0000;
      chk("R8 clear during idle", per_clk_en, model);
      bus_read(3'd1, r);
      chk("R4 cpu stat idle", r, 32'd0);
      chk("R8 still idle", {31'b0, cpu_clk_en}, 32'd0);
      @(negedge clk); wake_irq = 1'b1;
      @(negedge clk); wake_irq = 1'b0; #1;
      chk("R6 wake by irq", {31'b0, cpu_clk_en}, 32'd1);
   endtask

   task automatic t_fiq;
      bus_write(3'd0, 32'h1);
      @(negedge clk); insn_done = 1'b1;
      @(negedge clk); insn_done = 1'b0; #1;
      chk("R5 idle again", {31'b0, cpu_clk_en}, 32'd0);
      repeat (2) @(negedge clk);
      wake_fiq = 1'b1;
      @(negedge clk); wake_fiq = 1'b0; #1;
      chk("R6 wake by fiq", {31'b0, cpu_clk_en}, 32'd1);
   endtask

   task automatic t_cancel;
      // stop written together with a pending interrupt
      @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h1; wake_irq = 1'b1;
      @(negedge clk); bus_wr = 1'b0; wake_irq = 1'b0; insn_done = 1'b1;
      repeat (3) @(negedge clk);
      insn_done = 1'b0; #1;
      chk("R7 stop with irq ignored", {31'b0, cpu_clk_en}, 32'd1);
      // interrupt while waiting for insn_done
      bus_write(3'd0, 32'h1);
      @(negedge clk); wake_fiq = 1'b1; insn_done = 1'b1;
      @(negedge clk); wake_fiq = 1'b0;
      repeat (2) @(negedge clk);
      insn_done = 1'b0; #1;
      chk("R7 wake during drain", {31'b0, cpu_clk_en}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 after release", {31'b0, cpu_clk_en}, 32'd1);
      t_set();
      t_clear();
      t_idle_and_irq();
      t_fiq();
      t_cancel();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule